// File: doc/BRIEF.md
# Scratchpad MMIO Window with NOP Region

A memory-mapped test slave that sits on a simple single-cycle request bus. It decodes two areas inside its address space. The first is a 64-byte scratchpad. Software can write 1, 2, 4 or 8 bytes there at any byte offset and read the same bytes back, as long as the whole access lies inside the window. The second is an 8-byte NOP area. Writes to it are dropped. Reads from it return a fixed signature pattern, shifted by the byte offset of the access.

Any other address reads as all ones, and writes to it are ignored. A test program uses the block to check bus byte lanes, partial writes and unaligned transfers. It also serves as a read or write target with a known, cheap response time. Every request gets a one-cycle `ready_o` pulse on the following clock. The read data is registered and valid together with that pulse.

Top module: `scr_mmio_window`

## Requirements
- R1: After `rst_ni` is released, `ready_o` and `rdata_o` are zero and every scratchpad byte reads as 0x00.
- R2: Every request (`req_i` high for one cycle, read or write, any address) is answered by `ready_o` high in exactly the next cycle. `ready_o` is low in a cycle that follows no request.
- R3: `size_i` encodes the byte count: 0 is 1 byte, 1 is 2, 2 is 4 and 3 is 8. An accepted scratchpad write updates exactly that many bytes starting at the addressed byte, little-endian (`wdata_i[7:0]` goes to the lowest address). All other bytes are unchanged.
- R4: A scratchpad read returns the stored bytes little-endian in `rdata_o`, at any byte offset. Bytes of `rdata_o` at or above the access size are 0x00.
- R5: The scratchpad occupies `SCR_BASE` to `SCR_BASE+63`, with byte offset `addr_i[5:0]`. An access that starts below the window, or whose last byte lies past the window end, is not a scratchpad access. Such a write leaves the store unchanged, and such a read returns all ones.
- R6: A read at `NOP_BASE` returns the signature `SIG`. Size 8 gives `{SIG,SIG}`, size 4 gives `SIG`, size 2 gives `SIG[15:0]` and size 1 gives `SIG[7:0]`. Unused upper bytes are 0x00.
- R7: A read at `NOP_BASE+k` (k = 1 to 7) returns, in result byte i, byte k+i of the 8-byte pattern `{SIG,SIG}` (byte 0 = `SIG[7:0]`) when k+i < 8, and 0xFF otherwise. This holds for i below the access size. Bytes at or above the access size are 0x00.
- R8: Writes to `NOP_BASE` to `NOP_BASE+7` are discarded. Later NOP reads and scratchpad contents are unchanged.
- R9: A read of any address outside both areas returns all 64 bits set. A write there changes nothing.
- R10: `rdata_o` changes only in the cycle after a read request. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address within the block |
| size_i | input | 2 | Byte count code (0:1, 1:2, 2:4, 3:8) |
| wdata_i | input | 64 | Write data, little-endian lanes |
| ready_o | output | 1 | Completion pulse, one cycle after the request |
| rdata_o | output | 64 | Registered read data, valid with ready_o |

## Verification
A wrong lane select or offset in the store shows up as a misplaced or clobbered byte. It appears on the first read that covers the neighbouring bytes after the faulty write, so the bench reads back whole qwords after each partial write. A wrong window bound shows up as a store change, or as a non-all-ones result, for an access that straddles an edge. A wrong shift in the NOP pattern shows up on the first unaligned NOP read. All of these appear on `rdata_o` in the cycle of the `ready_o` pulse for the access that exposes them.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

  localparam int BUS_BYTES = 8;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_NOP  = 2'd1,
    RGN_SCR  = 2'd2
  } region_e;

  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/scr_decode.sv
`timescale 1ns/1ps
module scr_decode
  import scr_pkg::*;
#(
  parameter int AW        = 12,
  parameter int NOP_BASE  = 'h000,
  parameter int SCR_BASE  = 'h040,
  parameter int SCR_BYTES = 64,
  localparam int OW       = $clog2(SCR_BYTES)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output region_e       region_o,
  output logic [3:0]    nbytes_o,
  output logic [OW-1:0] scr_off_o,
  output logic [2:0]    nop_k_o
);

  logic [AW:0]   scr_rel;
  logic [AW:0]   scr_end;
  logic [AW-1:0] nop_rel;
  logic          scr_hit;
  logic          nop_hit;

  always_comb begin
    nbytes_o = size_to_bytes(size_i);
    // borrow in the top bit flags a start below the window
    scr_rel  = {1'b0, addr_i} - (AW+1)'(SCR_BASE);
    scr_end  = {1'b0, scr_rel[AW-1:0]} + (AW+1)'(nbytes_o);
    scr_hit  = !scr_rel[AW] && (scr_end <= (AW+1)'(SCR_BYTES));
    nop_rel  = addr_i - AW'(NOP_BASE);
    nop_hit  = nop_rel < AW'(BUS_BYTES);
    if (scr_hit)      region_o = RGN_SCR;
    else if (nop_hit) region_o = RGN_NOP;
    else              region_o = RGN_NONE;
    scr_off_o = addr_i[OW-1:0];
    nop_k_o   = nop_rel[2:0];
  end

endmodule

// File: rtl/scr_store.sv
`timescale 1ns/1ps
module scr_store
  import scr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int OW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [OW-1:0] off_i,
  input  logic [3:0]    nbytes_i,
  input  logic [63:0]   wdata_i,
  output logic [63:0]   rdata_o
);

  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] lane_hit;
  logic [2:0]       lane_sel [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_lane
    logic [OW-1:0] lane;
    assign lane        = OW'(j) - off_i;
    assign lane_hit[j] = wr_i && (int'(lane) < int'(nbytes_i));
    assign lane_sel[j] = lane[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= 8'h00;
    end else begin
      for (int j = 0; j < DEPTH; j++)
        if (lane_hit[j]) mem_q[j] <= wdata_i[8*lane_sel[j] +: 8];
    end
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rd
    logic [OW-1:0] idx;
    assign idx = off_i + OW'(i);
    assign rdata_o[8*i +: 8] = (4'(i) < nbytes_i) ? mem_q[idx] : 8'h00;
  end

endmodule

// File: rtl/scr_nop.sv
`timescale 1ns/1ps
module scr_nop
  import scr_pkg::*;
#(
  parameter logic [31:0] SIG = 32'h1234ABCD
) (
  input  logic [2:0]  k_i,
  input  logic [3:0]  nbytes_i,
  output logic [63:0] rdata_o
);

  localparam logic [63:0] PAT = {SIG, SIG};

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_byte
    logic [3:0] pos;
    logic [7:0] pat_byte;
    assign pos      = {1'b0, k_i} + 4'(i);
    assign pat_byte = pos[3] ? 8'hFF : PAT[8*pos[2:0] +: 8];
    assign rdata_o[8*i +: 8] = (4'(i) < nbytes_i) ? pat_byte : 8'h00;
  end

endmodule

// File: rtl/scr_mmio_window.sv
`timescale 1ns/1ps
module scr_mmio_window
  import scr_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          NOP_BASE  = 'h000,
  parameter int          SCR_BASE  = 'h040,
  parameter int          SCR_BYTES = 64,
  parameter logic [31:0] SIG       = 32'h1234ABCD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [63:0]   wdata_i,
  output logic          ready_o,
  output logic [63:0]   rdata_o
);

  localparam int OW = $clog2(SCR_BYTES);

  region_e       region;
  logic [3:0]    nbytes;
  logic [OW-1:0] scr_off;
  logic [2:0]    nop_k;
  logic [63:0]   scr_rd;
  logic [63:0]   nop_rd;
  logic [63:0]   rd_next;
  logic          ready_q;
  logic [63:0]   rdata_q;

  scr_decode #(
    .AW(AW), .NOP_BASE(NOP_BASE), .SCR_BASE(SCR_BASE), .SCR_BYTES(SCR_BYTES)
  ) i_decode (
    .addr_i(addr_i), .size_i(size_i), .region_o(region),
    .nbytes_o(nbytes), .scr_off_o(scr_off), .nop_k_o(nop_k)
  );

  scr_store #(.DEPTH(SCR_BYTES)) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(req_i && we_i && (region == RGN_SCR)),
    .off_i(scr_off), .nbytes_i(nbytes), .wdata_i(wdata_i), .rdata_o(scr_rd)
  );

  scr_nop #(.SIG(SIG)) i_nop (
    .k_i(nop_k), .nbytes_i(nbytes), .rdata_o(nop_rd)
  );

  always_comb begin
    unique case (region)
      RGN_SCR: rd_next = scr_rd;
      RGN_NOP: rd_next = nop_rd;
      default: rd_next = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      if (req_i && !we_i) rdata_q <= rd_next;
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/scr_mmio_window_chk.sv
`timescale 1ns/1ps
module scr_mmio_window_chk #(
  parameter int          AW        = 12,
  parameter int          NOP_BASE  = 'h000,
  parameter int          SCR_BASE  = 'h040,
  parameter int          SCR_BYTES = 64,
  parameter logic [31:0] SIG       = 32'h1234ABCD
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    size_i,
  input logic          ready_o,
  input logic [63:0]   rdata_o
);

  logic far_addr;
  assign far_addr = ({1'b0, addr_i} >= (AW+1)'(SCR_BASE + SCR_BYTES)) &&
                    ({1'b0, addr_i} >= (AW+1)'(NOP_BASE + 8));

  // R2
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);

  // R2
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R6
  nop_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'(NOP_BASE) && size_i == 2'd3) |=> rdata_o == {SIG, SIG});

  // R9
  unmapped_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && far_addr) |=> (rdata_o == '1));

endmodule

bind scr_mmio_window scr_mmio_window_chk #(
  .AW(AW), .NOP_BASE(NOP_BASE), .SCR_BASE(SCR_BASE), .SCR_BYTES(SCR_BYTES), .SIG(SIG)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .size_i(size_i), .ready_o(ready_o), .rdata_o(rdata_o)
);

// File: tb/test_scr_mmio_window.sv
`timescale 1ns/1ps
module test_scr_mmio_window;

  localparam int          AW   = 12;
  localparam int          NOPB = 'h000;
  localparam int          SCRB = 'h040;
  localparam logic [31:0] SIG  = 32'h1234ABCD;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = '0;
  logic [63:0]   wdata = '0;
  logic          ready;
  logic [63:0]   rdata;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] model [64];

  always #2 clk = ~clk;

  scr_mmio_window #(.AW(AW), .NOP_BASE(NOPB), .SCR_BASE(SCRB), .SCR_BYTES(64), .SIG(SIG))
  i_scr_mmio_window (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit in_scr(input int a, input int n);
    return (a >= SCRB) && (a + n <= SCRB + 64);
  endfunction

  function automatic logic [63:0] expect_rd(input int a, input logic [1:0] sz);
    int n = 1 << sz;
    logic [63:0] pat = {SIG, SIG};
    logic [63:0] r = '0;
    if (in_scr(a, n)) begin
      for (int i = 0; i < n; i++) r[8*i +: 8] = model[(a - SCRB + i) & 63];
    end else if (a >= NOPB && a < NOPB + 8) begin
      for (int i = 0; i < n; i++)
        r[8*i +: 8] = ((a - NOPB + i) < 8) ? pat[8*(a - NOPB + i) +: 8] : 8'hFF;
    end else begin
      r = '1;
    end
    return r;
  endfunction

  // one request; ready_o is sampled at the negedge after the capturing edge
  task automatic access(input logic w, input int a, input logic [1:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); size = sz; wdata = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R2 ready after request", {63'd0, ready}, 64'd1);
    rd = rdata;
    if (w && in_scr(a, 1 << sz))
      for (int i = 0; i < (1 << sz); i++) model[a - SCRB + i] = wd[8*i +: 8];
  endtask

  task automatic wr(input int a, input logic [1:0] sz, input logic [63:0] wd);
    logic [63:0] d;
    access(1'b1, a, sz, wd, d);
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [1:0] sz);
    logic [63:0] d;
    access(1'b0, a, sz, '0, d);
    check(tag, d, expect_rd(a, sz));
  endtask

  task automatic dump_chk(input string tag);
    for (int q = 0; q < 8; q++) rd_chk(tag, SCRB + 8*q, 2'd3);
  endtask

  task automatic t_reset;
    check("R1 ready after reset", {63'd0, ready}, 64'd0);
    check("R1 rdata after reset", rdata, 64'd0);
    dump_chk("R1 store zero");
  endtask

  task automatic t_ready;
    wr(SCRB, 2'd0, 64'h5A);
    @(negedge clk);
    check("R2 ready idle low", {63'd0, ready}, 64'd0);
    rd_chk("R2 read", 'h200, 2'd1);
    @(negedge clk);
    check("R2 ready idle after read", {63'd0, ready}, 64'd0);
  endtask

  task automatic t_sizes;
    wr(SCRB, 2'd3, 64'h1122334455667788);
    wr(SCRB + 3, 2'd0, 64'hFFFF_FFFF_FFFF_FFAA);
    rd_chk("R3 byte write merge", SCRB, 2'd3);
    wr(SCRB + 5, 2'd1, 64'h0000_0000_0000_BEEF);
    rd_chk("R3 half write merge", SCRB, 2'd3);
    rd_chk("R3 half write next qword", SCRB + 8, 2'd3);
    wr(SCRB + 9, 2'd2, 64'h0123_4567_CAFE_F00D);
    rd_chk("R3 word write unaligned", SCRB + 8, 2'd3);
    wr(SCRB + 27, 2'd3, 64'hA1B2_C3D4_E5F6_0718);
    rd_chk("R3 dword straddle low", SCRB + 24, 2'd3);
    rd_chk("R3 dword straddle high", SCRB + 32, 2'd3);
    rd_chk("R4 read size1 unaligned", SCRB + 29, 2'd0);
    rd_chk("R4 read size2 odd", SCRB + 7, 2'd1);
    rd_chk("R4 read size4 odd", SCRB + 11, 2'd2);
    rd_chk("R4 read size8 odd", SCRB + 27, 2'd3);
    dump_chk("R3 full store");
  endtask

  task automatic t_bounds;
    wr(SCRB + 56, 2'd3, 64'h8877_6655_4433_2211);
    rd_chk("R5 last qword", SCRB + 56, 2'd3);
    wr(SCRB + 57, 2'd3, 64'hDEAD_DEAD_DEAD_DEAD);
    rd_chk("R5 overrun write ignored", SCRB + 56, 2'd3);
    rd_chk("R5 overrun read ones", SCRB + 57, 2'd3);
    rd_chk("R5 overrun read ones size2", SCRB + 63, 2'd1);
    rd_chk("R5 last byte", SCRB + 63, 2'd0);
    wr(SCRB - 1, 2'd1, 64'h0000_0000_0000_9999);
    rd_chk("R5 underrun write ignored", SCRB, 2'd3);
    rd_chk("R5 underrun read ones", SCRB - 4, 2'd3);
  endtask

  task automatic t_nop_aligned;
    for (int s = 0; s < 4; s++) rd_chk("R6 nop aligned", NOPB, 2'(s));
  endtask

  task automatic t_nop_unaligned;
    for (int k = 1; k < 8; k++)
      for (int s = 0; s < 4; s++) rd_chk("R7 nop offset", NOPB + k, 2'(s));
  endtask

  task automatic t_nop_write;
    for (int k = 0; k < 8; k++) wr(NOPB + k, 2'd0, 64'h00);
    wr(NOPB, 2'd3, 64'h0);
    rd_chk("R8 nop read after write", NOPB, 2'd3);
    rd_chk("R8 nop offset after write", NOPB + 3, 2'd2);
    dump_chk("R8 store after nop write");
  endtask

  task automatic t_unmapped;
    rd_chk("R9 read past window", SCRB + 64, 2'd0);
    rd_chk("R9 read top", (1 << AW) - 1, 2'd3);
    rd_chk("R9 read gap", 'h20, 2'd2);
    wr(SCRB + 64, 2'd3, 64'h0);
    wr('h20, 2'd3, 64'h0);
    dump_chk("R9 store after unmapped write");
  endtask

  task automatic t_hold;
    logic [63:0] d;
    rd_chk("R10 setup read", NOPB + 2, 2'd2);
    d = rdata;
    wr(SCRB + 16, 2'd3, 64'h0F0F_0F0F_0F0F_0F0F);
    check("R10 hold after write", rdata, d);
    repeat (3) @(negedge clk);
    check("R10 hold when idle", rdata, d);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready();
    t_sizes();
    t_bounds();
    t_nop_aligned();
    t_nop_unaligned();
    t_nop_write();
    t_unmapped();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule